// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is the small, fully associative translation cache inside a memory-management unit. It serves the user half of a 32-bit virtual space with 4 KB pages. A lookup presents a 31-bit virtual address, the identifier of the running address space and the kind of access (read or write, user or supervisor). In the same cycle the block answers with a hit flag, a protection-fault flag, a physical-address-valid flag, the 36-bit physical address and the three cache-attribute bits stored with the entry. A hit therefore avoids the memory access to the page table that a translation would otherwise need.

Software or a page walker fills the cache through an insert port. Each insert carries the page numbers, the identifier, the shared-page (global) flag, the modified (dirty) flag, the valid flag and two permission flags. An insert goes to the lowest-numbered empty slot. When no slot is empty, a round-robin pointer picks the slot. A flush input empties the whole cache in one clock, so the cache stays correct on a context switch even when identifiers are not used.

Top module: `asid_tlb`

## Requirements
- R1: The page number is `lk_va[30:12]` and the page offset is `lk_va[11:0]`. The offset is copied unchanged into `lk_pa[11:0]`.
- R2: On a hit that raises no fault, `lk_pa_ok` is 1, `lk_pa` is the stored 24-bit frame number followed by the offset, and `lk_attr` is the entry's attribute bits.
- R3: A hit is a fault when it is a write to an entry whose `ins_wr_ok` was 0, or a user access to an entry whose `ins_usr_ok` was 0. On a fault `lk_hit`=1, `lk_fault`=1, `lk_pa_ok`=0 and `lk_pa`=0.
- R4: A write hit on an entry whose dirty flag is 0 is a fault, even when writes are permitted.
- R5: An entry matches only when its identifier equals `lk_asid`. When its global flag is 1, the identifier is not compared.
- R6: Two entries with the same page number and different identifiers may be present together. Each lookup returns the frame of its own identifier.
- R7: `flush` clears every entry at the next clock edge. After that edge every lookup misses.
- R8: When no valid entry matches, `lk_hit`, `lk_fault` and `lk_pa_ok` are 0, and `lk_pa` and `lk_attr` are 0. After reset every lookup misses.
- R9: An insert writes the lowest-indexed invalid slot. When all slots are valid, it writes the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances (wrapping) only on an insert that used it.
- R10: A lookup responds in the same cycle. An insert is visible from the next clock edge. An insert in the same cycle as `flush` is dropped.
- R11: An entry inserted with `ins_valid`=0 never matches, and its slot counts as empty for later inserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_va | input | 31 | Lookup virtual address (user half) |
| lk_asid | input | 8 | Current address-space identifier |
| lk_write | input | 1 | Lookup is a write |
| lk_user | input | 1 | Lookup is a user-mode access |
| lk_hit | output | 1 | A valid entry matched |
| lk_fault | output | 1 | Matched entry forbids this access |
| lk_pa_ok | output | 1 | Physical address is valid |
| lk_pa | output | 36 | Physical address |
| lk_attr | output | 3 | Cache-attribute bits of the matched entry |
| ins_en | input | 1 | Insert request |
| ins_vpn | input | 19 | Page number to insert |
| ins_pfn | input | 24 | Frame number to insert |
| ins_asid | input | 8 | Identifier of the new entry |
| ins_global | input | 1 | Entry matches any identifier |
| ins_dirty | input | 1 | Page already modified |
| ins_valid | input | 1 | Entry is valid |
| ins_wr_ok | input | 1 | Writes permitted |
| ins_usr_ok | input | 1 | User access permitted |
| ins_attr | input | 3 | Cache-attribute bits |
| flush | input | 1 | Invalidate all entries |

## Verification
Lookup results are combinational. The bench changes the lookup inputs between clock edges and samples the outputs one nanosecond later, inside the same cycle. Inserts and flushes are driven on a falling edge and take effect at the next rising edge. The bench therefore starts every follow-up lookup on the falling edge after that rising edge, never before it. A bench-side model of the slots and the round-robin pointer predicts each expected result. The model is exercised through identifier sharing, global entries, replacement on wrap-around, invalid inserts, a flush that collides with an insert, and every combination of permission and access type.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int OFF_W  = 12;
  parameter int VPN_W  = 19;
  parameter int PFN_W  = 24;
  parameter int ASID_W = 8;
  parameter int ATTR_W = 3;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic              dirty;
    logic              valid;
    logic              wr_ok;
    logic              usr_ok;
    logic [ATTR_W-1:0] attr;
  } entry_t;
endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              we,
  input  entry_t            wdata,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              match,
  output entry_t            q
);
  logic   vld;
  entry_t body;

  always_ff @(posedge clk) begin
    if (rst || flush) vld <= 1'b0;
    else if (we)      vld <= wdata.valid;
  end

  always_ff @(posedge clk) begin
    if (we) body <= wdata;
  end

  always_comb begin
    q       = body;
    q.valid = vld;
  end

  assign match = vld && (body.vpn == lk_vpn) && (body.glob || body.asid == lk_asid);

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(vld) |-> $past(flush || we)); // R7
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ins_go,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   sel
);
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] first;
  logic             found;

  always_comb begin
    found = 1'b0;
    first = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !valid_vec[i]) begin
        found = 1'b1;
        first = IDX_W'(i);
      end
    end
    sel = found ? first : ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (ins_go && !found)
      ptr <= (ptr == IDX_W'(ENTRIES-1)) ? '0 : ptr + 1'b1;
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ins_go |=> $stable(ptr)); // R9
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  input  logic              lk_user,
  output logic              lk_hit,
  output logic              lk_fault,
  output logic              lk_pa_ok,
  output logic [PA_W-1:0]   lk_pa,
  output logic [ATTR_W-1:0] lk_attr,
  input  logic              ins_en,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [PFN_W-1:0]  ins_pfn,
  input  logic [ASID_W-1:0] ins_asid,
  input  logic              ins_global,
  input  logic              ins_dirty,
  input  logic              ins_valid,
  input  logic              ins_wr_ok,
  input  logic              ins_usr_ok,
  input  logic [ATTR_W-1:0] ins_attr,
  input  logic              flush
);
  entry_t             wdata;
  entry_t             slot_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   sel;
  logic               ins_go;
  entry_t             hit_e;
  logic               hit;
  logic               deny;

  assign ins_go = ins_en && !flush;

  always_comb begin
    wdata.vpn    = ins_vpn;
    wdata.pfn    = ins_pfn;
    wdata.asid   = ins_asid;
    wdata.glob   = ins_global;
    wdata.dirty  = ins_dirty;
    wdata.valid  = ins_valid;
    wdata.wr_ok  = ins_wr_ok;
    wdata.usr_ok = ins_usr_ok;
    wdata.attr   = ins_attr;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlb_slot u_slot (
      .clk     (clk),
      .rst     (rst),
      .flush   (flush),
      .we      (ins_go && (sel == IDX_W'(g))),
      .wdata   (wdata),
      .lk_vpn  (lk_va[VA_W-1:OFF_W]),
      .lk_asid (lk_asid),
      .match   (match[g]),
      .q       (slot_q[g])
    );
    assign valid_vec[g] = slot_q[g].valid;
  end

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst       (rst),
    .ins_go    (ins_go),
    .valid_vec (valid_vec),
    .sel       (sel)
  );

  always_comb begin
    hit   = 1'b0;
    hit_e = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit   = 1'b1;
        hit_e = entry_t'(hit_e | slot_q[i]);
      end
    end
  end

  assign deny     = (lk_write && (!hit_e.wr_ok || !hit_e.dirty)) || (lk_user && !hit_e.usr_ok);
  assign lk_hit   = hit;
  assign lk_fault = hit && deny;
  assign lk_pa_ok = hit && !deny;
  assign lk_pa    = lk_pa_ok ? {hit_e.pfn, lk_va[OFF_W-1:0]} : '0;
  assign lk_attr  = hit ? hit_e.attr : '0;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> !lk_hit); // R7
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    lk_fault |-> (lk_hit && !lk_pa_ok)); // R3
  AST_OFFSET_THRU: assert property (@(posedge clk) disable iff (rst)
    lk_pa_ok |-> (lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0])); // R1
endmodule

// File: tb/sim_asid_tlb.sv
module sim_asid_tlb;
  localparam int N = 8;

  logic        clk = 0;
  logic        rst = 1;
  logic [30:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_write = 0, lk_user = 0;
  logic        lk_hit, lk_fault, lk_pa_ok;
  logic [35:0] lk_pa;
  logic [2:0]  lk_attr;
  logic        ins_en = 0;
  logic [18:0] ins_vpn = '0;
  logic [23:0] ins_pfn = '0;
  logic [7:0]  ins_asid = '0;
  logic        ins_global = 0, ins_dirty = 0, ins_valid = 0, ins_wr_ok = 0, ins_usr_ok = 0;
  logic [2:0]  ins_attr = '0;
  logic        flush = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  logic        m_v [N];
  logic [18:0] m_vpn [N];
  logic [23:0] m_pfn [N];
  logic [7:0]  m_asid [N];
  logic        m_g [N], m_d [N], m_w [N], m_u [N];
  logic [2:0]  m_attr [N];
  int          m_ptr;

  always #2 clk = ~clk;

  asid_tlb #(.ENTRIES(N)) u0 (.*);

  task automatic model_clear();
    for (int i = 0; i < N; i++) m_v[i] = 0;
  endtask

  task automatic do_ins(input logic [18:0] vpn, input logic [23:0] pfn, input logic [7:0] asid,
                        input logic g, input logic d, input logic v, input logic w,
                        input logic u, input logic [2:0] attr, input logic with_flush);
    int s;
    @(negedge clk);
    ins_en = 1; ins_vpn = vpn; ins_pfn = pfn; ins_asid = asid; ins_global = g;
    ins_dirty = d; ins_valid = v; ins_wr_ok = w; ins_usr_ok = u; ins_attr = attr;
    flush = with_flush;
    @(negedge clk);
    ins_en = 0; flush = 0;
    if (with_flush) begin
      model_clear();
    end else begin
      s = -1;
      for (int i = 0; i < N; i++) if (s < 0 && !m_v[i]) s = i;
      if (s < 0) begin s = m_ptr; m_ptr = (m_ptr + 1) % N; end
      m_v[s] = v; m_vpn[s] = vpn; m_pfn[s] = pfn; m_asid[s] = asid; m_g[s] = g;
      m_d[s] = d; m_w[s] = w; m_u[s] = u; m_attr[s] = attr;
    end
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    model_clear();
  endtask

  task automatic check_lk(input logic [30:0] va, input logic [7:0] asid,
                          input logic wr, input logic usr, input string req);
    logic e_hit, e_fault, e_ok; logic [35:0] e_pa; logic [2:0] e_attr; int k;
    lk_va = va; lk_asid = asid; lk_write = wr; lk_user = usr;
    #1;
    k = -1;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == va[30:12] && (m_g[i] || m_asid[i] == asid)) k = i;
    e_hit = (k >= 0);
    e_fault = e_hit && ((wr && (!m_w[k] || !m_d[k])) || (usr && !m_u[k]));
    e_ok = e_hit && !e_fault;
    e_pa = e_ok ? {m_pfn[k], va[11:0]} : 36'h0;
    e_attr = e_hit ? m_attr[k] : 3'h0;
    checks++;
    if ({lk_hit, lk_fault, lk_pa_ok, lk_pa, lk_attr} !== {e_hit, e_fault, e_ok, e_pa, e_attr}) begin
      fails++;
      $display("FAIL %s va=%h asid=%h: got hit=%b flt=%b ok=%b pa=%h attr=%h, expected hit=%b flt=%b ok=%b pa=%h attr=%h",
               req, va, asid, lk_hit, lk_fault, lk_pa_ok, lk_pa, lk_attr, e_hit, e_fault, e_ok, e_pa, e_attr);
    end
  endtask

  task automatic sweep_model(input string req);
    for (int i = 0; i < N; i++)
      if (m_v[i]) check_lk({m_vpn[i], 12'h5a4}, m_asid[i], 0, 0, req);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_clear(); m_ptr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R8: reset state misses
    check_lk(31'h1234_5678, 8'h00, 0, 0, "R8 reset");
    check_lk(31'h0000_0000, 8'hff, 1, 1, "R8 reset");
    // R5 R6: same page, two identifiers, plus a global page
    do_ins(19'h12345, 24'hA00001, 8'd1, 0, 1, 1, 1, 1, 3'd1, 0);
    do_ins(19'h12345, 24'hB00002, 8'd2, 0, 1, 1, 1, 1, 3'd2, 0);
    do_ins(19'h00077, 24'hC00003, 8'd3, 1, 1, 1, 1, 1, 3'd5, 0);
    check_lk({19'h12345, 12'h010}, 8'd1, 0, 1, "R6 own asid1");
    check_lk({19'h12345, 12'h010}, 8'd2, 0, 1, "R6 own asid2");
    check_lk({19'h12345, 12'h010}, 8'd3, 0, 1, "R5 foreign asid miss");
    check_lk({19'h00077, 12'hfff}, 8'd200, 0, 0, "R5 global any asid");
    // R9: fill remaining slots, then wrap with round-robin
    for (int i = 0; i < 5; i++)
      do_ins(19'h40000 + 19'(i), 24'h100000 + 24'(i * 7), 8'd4, 0, 1, 1, 1, 1, 3'(i), 0);
    sweep_model("R2 full sweep");
    do_ins(19'h55555, 24'hD00004, 8'd4, 0, 1, 1, 1, 1, 3'd6, 0);
    check_lk({19'h12345, 12'h000}, 8'd1, 0, 0, "R9 slot0 replaced");
    check_lk({19'h55555, 12'h001}, 8'd4, 0, 0, "R9 new entry hit");
    check_lk({19'h12345, 12'h000}, 8'd2, 0, 0, "R9 slot1 kept");
    do_ins(19'h55556, 24'hD00005, 8'd4, 0, 1, 1, 1, 1, 3'd7, 0);
    check_lk({19'h12345, 12'h000}, 8'd2, 0, 0, "R9 slot1 replaced");
    // R11: invalid insert never matches; its slot is reused first
    do_ins(19'h66666, 24'hE00006, 8'd4, 0, 1, 0, 1, 1, 3'd1, 0);
    check_lk({19'h66666, 12'h000}, 8'd4, 0, 0, "R11 invalid no match");
    do_ins(19'h77777, 24'hF00007, 8'd4, 0, 1, 1, 1, 1, 3'd2, 0);
    do_ins(19'h77778, 24'hF00008, 8'd4, 0, 1, 1, 1, 1, 3'd3, 0);
    sweep_model("R9 R11 placement sweep");
    check_lk({19'h40000, 12'h000}, 8'd4, 0, 0, "R9 pointer order");
    // R10: insert same cycle as flush is dropped; R7 all miss
    do_ins(19'h0abcd, 24'h123456, 8'd4, 0, 1, 1, 1, 1, 3'd4, 1);
    check_lk({19'h0abcd, 12'h000}, 8'd4, 0, 0, "R10 insert dropped on flush");
    check_lk({19'h77777, 12'h000}, 8'd4, 0, 0, "R7 flushed");
    check_lk({19'h00077, 12'h000}, 8'd3, 0, 0, "R7 global flushed");
    // R3 R4: all permission x access combinations
    for (int p = 0; p < 8; p++) begin
      do_flush();
      do_ins(19'h2468a, 24'h00f000 + 24'(p), 8'd9, 0, p[2], 1, p[0], p[1], 3'(p), 0);
      for (int a = 0; a < 4; a++)
        check_lk({19'h2468a, 12'h3c0 + 12'(a)}, 8'd9, a[0], a[1], "R3 R4 protection");
    end
    // R1 R2: offset pass-through
    do_flush();
    do_ins(19'h7ffff, 24'hffffff, 8'd0, 0, 1, 1, 1, 1, 3'd3, 0);
    check_lk({19'h7ffff, 12'h000}, 8'd0, 1, 1, "R1 offset zero");
    check_lk({19'h7ffff, 12'hfff}, 8'd0, 1, 1, "R1 offset max");
    check_lk({19'h7ffff, 12'ha5a}, 8'd0, 0, 1, "R2 pa");
    check_lk({19'h3ffff, 12'ha5a}, 8'd0, 0, 1, "R8 near miss");
    // R10: visible one edge after insert (model updated only after the edge)
    @(negedge clk);
    ins_en = 1; ins_vpn = 19'h13579; ins_pfn = 24'h777777; ins_asid = 8'd0; ins_global = 0;
    ins_dirty = 1; ins_valid = 1; ins_wr_ok = 1; ins_usr_ok = 1; ins_attr = 3'd0;
    check_lk({19'h13579, 12'h000}, 8'd0, 0, 0, "R10 not before edge");
    @(negedge clk); ins_en = 0;
    m_v[1] = 1; m_vpn[1] = 19'h13579; m_pfn[1] = 24'h777777; m_asid[1] = 0; m_g[1] = 0;
    m_d[1] = 1; m_w[1] = 1; m_u[1] = 1; m_attr[1] = 0;
    check_lk({19'h13579, 12'h001}, 8'd0, 0, 0, "R10 after edge");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule